// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator that is presented as two 32-bit halves, a high word and a low word. It has two operations. The long operation takes both 32-bit operands in full. The word operation uses only the low 16 bits of each operand, read as signed values. A saturation-mode bit, sampled when an operation is accepted, switches each operation to its own clamping rule. With the bit clear, the 64-bit sum simply wraps.

The multiply takes a fixed number of cycles, set by a parameter. A one-cycle done pulse marks the cycle in which the updated accumulator is first visible. Software-side logic can zero the accumulator with a synchronous clear, or overwrite either half through a shared load data bus. Operand fetch and pointer updates belong to the surrounding datapath.

Top module: `mac_sat_unit`

## Requirements
- R1: With `op_i`=0 (long), both 32-bit operands are sign-extended and multiplied. The product is added to the 64-bit value {hi_o, lo_o}. With saturation off, the wrapped 64-bit sum is written back as hi_o (bits 63..32) and lo_o (bits 31..0).
- R2: With `op_i`=1 (word), only bits 15..0 of each operand are used, sign-extended from bit 15. Bits 31..16 of the operands have no effect. With saturation off, the wrapped 64-bit sum is written back.
- R3: Long operation, saturation on, negative 64-bit sum: hi_o bits 31..16 become all ones. hi_o bits 15..0 and lo_o come from the sum.
- R4: Long operation, saturation on, sum zero or positive: hi_o keeps only bits 14..0 of the sum's high word, and its other bits are zero. lo_o comes from the sum.
- R5: Word operation, saturation on, sum below -2^31: hi_o becomes 1 and lo_o becomes 0x80000000.
- R6: Word operation, saturation on, sum above 0x7FFFFFFF: hi_o becomes 1 and lo_o becomes 0x7FFFFFFF.
- R7: Word operation, saturation on, sum within [-2^31, 2^31-1], bounds included: the full 64-bit sum is written unchanged.
- R8: A start accepted at clock edge E is written to the accumulator at edge E+MUL_LAT. `done_o` is high for exactly the one cycle that follows that edge.
- R9: `start_i` is ignored from the edge that accepts an operation through that operation's write-back edge, inclusive. Operands presented during that window do not change the result, and they produce no additional done pulse.
- R10: Reset zeroes hi_o and lo_o and holds `done_o` low. `clr_i` zeroes both words at the next edge, and it takes priority over load strobes and over a write-back in the same cycle.
- R11: `ld_hi_i` or `ld_lo_i` writes `ld_data_i` into that word at the next edge. A load overrides a write-back for the loaded word only, and the other word still takes the write-back.
- R12: `op_i` and `sat_i` are sampled with the operands when a start is accepted. Later changes to them do not affect an operation already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted when no operation is outstanding |
| op_i | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| sat_i | input | 1 | Saturation mode for the started operation |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| clr_i | input | 1 | Synchronous accumulator clear |
| ld_hi_i | input | 1 | Load strobe for the high word |
| ld_lo_i | input | 1 | Load strobe for the low word |
| ld_data_i | input | 32 | Data for the load strobes |
| hi_o | output | 32 | Accumulator high word |
| lo_o | output | 32 | Accumulator low word |
| done_o | output | 1 | One-cycle pulse after a write-back |

## Verification
Each result is due MUL_LAT edges after the edge that accepts the start. The bench drives inputs on falling edges and steps exactly MUL_LAT falling edges past the accepting edge before it reads `done_o` and the two words. It also checks that `done_o` is low on every falling edge before that point and on the one after it. Clear and load take effect at the first edge, so the bench reads them on the falling edge that follows. For collisions with a write-back, the strobe is raised only in the cycle that ends at the write-back edge. A sweep over operands, preloads, both operations and both modes compares every result with a 64-bit arithmetic model built into the bench.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int MAC_DW = 32;
    localparam int HALF_W = 16;
    localparam int ACC_W  = 2 * MAC_DW;

    typedef enum logic {
        OP_LONG = 1'b0,
        OP_WORD = 1'b1
    } mac_op_e;

    typedef struct packed {
        mac_op_e            op;
        logic               sat;
        logic [MAC_DW-1:0]  a;
        logic [MAC_DW-1:0]  b;
    } mac_opnd_t;

    typedef struct packed {
        mac_op_e            op;
        logic               sat;
        logic [ACC_W-1:0]   prod;
    } mac_prod_t;

    function automatic logic [MAC_DW-1:0] ext_opnd(mac_op_e op, logic [MAC_DW-1:0] v);
        if (op == OP_WORD)
            return {{(MAC_DW-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
        return v;
    endfunction

    function automatic logic [ACC_W-1:0] sext_full(logic [MAC_DW-1:0] v);
        return {{MAC_DW{v[MAC_DW-1]}}, v};
    endfunction

endpackage

// File: rtl/mac_mul.sv
module mac_mul
    import mac_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  mac_op_e            op_i,
    input  logic               sat_i,
    input  logic [MAC_DW-1:0]  a_i,
    input  logic [MAC_DW-1:0]  b_i,
    output mac_prod_t          res_o,
    output logic               res_vld_o
);

    logic [LAT-1:0] vld;
    logic           busy;
    logic           accept;
    mac_opnd_t      s0;
    mac_prod_t      p0;
    logic [ACC_W-1:0] ax, bx;

    assign busy   = |vld;
    assign accept = start_i && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            vld[0] <= accept;
            for (int k = 1; k < LAT; k++)
                vld[k] <= vld[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            s0.op  <= op_i;
            s0.sat <= sat_i;
            s0.a   <= ext_opnd(op_i, a_i);
            s0.b   <= ext_opnd(op_i, b_i);
        end
    end

    always_comb begin
        ax      = sext_full(s0.a);
        bx      = sext_full(s0.b);
        p0.op   = s0.op;
        p0.sat  = s0.sat;
        p0.prod = ax * bx;
    end

    generate
        if (LAT == 1) begin : g_comb
            assign res_o = p0;
        end else begin : g_pipe
            mac_prod_t stg [LAT-1];
            always_ff @(posedge clk) begin
                stg[0] <= p0;
                for (int k = 1; k < LAT-1; k++)
                    stg[k] <= stg[k-1];
            end
            assign res_o = stg[LAT-2];
        end
    endgenerate

    assign res_vld_o = vld[LAT-1];

endmodule

// File: rtl/mac_sat.sv
module mac_sat
    import mac_pkg::*;
(
    input  mac_op_e            op_i,
    input  logic               sat_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [ACC_W-1:0]   prod_i,
    output logic [MAC_DW-1:0]  hi_o,
    output logic [MAC_DW-1:0]  lo_o
);

    localparam int QW = MAC_DW / 2;
    localparam logic [MAC_DW-1:0] HI_SET  = {{QW{1'b1}}, {QW{1'b0}}};
    localparam logic [MAC_DW-1:0] HI_KEEP = {{(QW+1){1'b0}}, {(QW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] W_MAX = {{(ACC_W-MAC_DW+1){1'b0}}, {(MAC_DW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] W_MIN = ~W_MAX;
    localparam logic [MAC_DW-1:0] MARK    = MAC_DW'(1);
    localparam logic [MAC_DW-1:0] LO_MAX  = {1'b0, {(MAC_DW-1){1'b1}}};
    localparam logic [MAC_DW-1:0] LO_MIN  = {1'b1, {(MAC_DW-1){1'b0}}};

    logic signed [ACC_W-1:0] sum;

    always_comb begin
        sum  = $signed(acc_i) + $signed(prod_i);
        hi_o = sum[ACC_W-1:MAC_DW];
        lo_o = sum[MAC_DW-1:0];
        if (sat_i) begin
            if (op_i == OP_LONG) begin
                if (sum[ACC_W-1]) hi_o = hi_o | HI_SET;
                else              hi_o = hi_o & HI_KEEP;
            end else if (sum < W_MIN) begin
                hi_o = MARK;
                lo_o = LO_MIN;
            end else if (sum > W_MAX) begin
                hi_o = MARK;
                lo_o = LO_MAX;
            end
        end
    end

endmodule

// File: rtl/mac_acc.sv
module mac_acc
    import mac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               ld_hi_i,
    input  logic               ld_lo_i,
    input  logic [MAC_DW-1:0]  ld_data_i,
    input  logic               wb_i,
    input  logic [MAC_DW-1:0]  wb_hi_i,
    input  logic [MAC_DW-1:0]  wb_lo_i,
    output logic [MAC_DW-1:0]  hi_o,
    output logic [MAC_DW-1:0]  lo_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            hi_o <= '0;
            lo_o <= '0;
        end else begin
            if (ld_hi_i)   hi_o <= ld_data_i;
            else if (wb_i) hi_o <= wb_hi_i;
            if (ld_lo_i)   lo_o <= ld_data_i;
            else if (wb_i) lo_o <= wb_lo_i;
        end
    end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int MUL_LAT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               op_i,
    input  logic               sat_i,
    input  logic [MAC_DW-1:0]  a_i,
    input  logic [MAC_DW-1:0]  b_i,
    input  logic               clr_i,
    input  logic               ld_hi_i,
    input  logic               ld_lo_i,
    input  logic [MAC_DW-1:0]  ld_data_i,
    output logic [MAC_DW-1:0]  hi_o,
    output logic [MAC_DW-1:0]  lo_o,
    output logic               done_o
);

    mac_prod_t          wb;
    logic               wb_vld;
    logic [MAC_DW-1:0]  nx_hi, nx_lo;

    mac_mul #(.LAT(MUL_LAT)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .op_i      (mac_op_e'(op_i)),
        .sat_i     (sat_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .res_o     (wb),
        .res_vld_o (wb_vld)
    );

    mac_sat u_sat (
        .op_i   (wb.op),
        .sat_i  (wb.sat),
        .acc_i  ({hi_o, lo_o}),
        .prod_i (wb.prod),
        .hi_o   (nx_hi),
        .lo_o   (nx_lo)
    );

    mac_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr_i),
        .ld_hi_i   (ld_hi_i),
        .ld_lo_i   (ld_lo_i),
        .ld_data_i (ld_data_i),
        .wb_i      (wb_vld),
        .wb_hi_i   (nx_hi),
        .wb_lo_i   (nx_lo),
        .hi_o      (hi_o),
        .lo_o      (lo_o)
    );

    always_ff @(posedge clk) begin
        if (rst) done_o <= 1'b0;
        else     done_o <= wb_vld;
    end

endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk
    import mac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               clr_i,
    input logic               ld_hi_i,
    input logic               ld_lo_i,
    input logic [MAC_DW-1:0]  ld_data_i,
    input logic [MAC_DW-1:0]  hi_o,
    input logic [MAC_DW-1:0]  lo_o,
    input logic               done_o,
    input logic               wb_vld,
    input mac_prod_t          wb
);

    localparam int QW = MAC_DW / 2;

    p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (hi_o == '0 && lo_o == '0));

    p_load_hi_r11: assert property (@(posedge clk) disable iff (rst)
        (ld_hi_i && !clr_i) |=> hi_o == $past(ld_data_i));

    p_load_lo_r11: assert property (@(posedge clk) disable iff (rst)
        (ld_lo_i && !clr_i) |=> lo_o == $past(ld_data_i));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3 and R4: saturated long result leaves the high word sign-filled or masked
    p_long_sat_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_vld && wb.op == OP_LONG && wb.sat && !clr_i && !ld_hi_i)
        |=> (hi_o[MAC_DW-1:QW] == '1 || hi_o[MAC_DW-1:QW-1] == '0));

    // R5, R6 and R7: saturated word result has a high word of 0, 1 or all ones
    p_word_sat_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (wb_vld && wb.op == OP_WORD && wb.sat && !clr_i && !ld_hi_i)
        |=> (hi_o == '0 || hi_o == MAC_DW'(1) || hi_o == '1));

endmodule

bind mac_sat_unit mac_sat_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_i),
    .ld_hi_i   (ld_hi_i),
    .ld_lo_i   (ld_lo_i),
    .ld_data_i (ld_data_i),
    .hi_o      (hi_o),
    .lo_o      (lo_o),
    .done_o    (done_o),
    .wb_vld    (wb_vld),
    .wb        (wb)
);

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;

    localparam int LAT = 2;
    localparam longint WMAX = 64'sd2147483647;
    localparam longint WMIN = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, op_i = 1'b0, sat_i = 1'b0;
    logic [31:0] a_i = '0, b_i = '0, ld_data_i = '0;
    logic        clr_i = 1'b0, ld_hi_i = 1'b0, ld_lo_i = 1'b0;
    logic [31:0] hi_o, lo_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mac_sat_unit #(.MUL_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .sat_i(sat_i),
        .a_i(a_i), .b_i(b_i), .clr_i(clr_i), .ld_hi_i(ld_hi_i), .ld_lo_i(ld_lo_i),
        .ld_data_i(ld_data_i), .hi_o(hi_o), .lo_o(lo_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input bit op, input bit sat, input logic [31:0] a,
                                          input logic [31:0] b, input logic [63:0] acc,
                                          output string req);
        longint p, s;
        logic [31:0] h, l;
        if (op) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        else    p = longint'($signed(a)) * longint'($signed(b));
        s = longint'(acc) + p;
        h = s[63:32];
        l = s[31:0];
        req = op ? "R2" : "R1";
        if (sat && !op) begin
            if (s < 0) begin h = h | 32'hFFFF0000; req = "R3"; end
            else       begin h = h & 32'h00007FFF; req = "R4"; end
        end else if (sat && op) begin
            if (s < WMIN)      begin h = 32'd1; l = 32'h80000000; req = "R5"; end
            else if (s > WMAX) begin h = 32'd1; l = 32'h7FFFFFFF; req = "R6"; end
            else               req = "R7";
        end
        return {h, l};
    endfunction

    task automatic load_acc(input logic [63:0] v);
        ld_data_i = v[63:32]; ld_hi_i = 1'b1;
        @(negedge clk);
        ld_hi_i = 1'b0; ld_data_i = v[31:0]; ld_lo_i = 1'b1;
        @(negedge clk);
        ld_lo_i = 1'b0;
    endtask

    task automatic run_op(input bit op, input bit sat, input logic [31:0] a,
                          input logic [31:0] b, input logic [63:0] exp, input string req);
        op_i = op; sat_i = sat; a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < LAT; i++) begin
            chk("R8 done early", {63'd0, done_o}, 64'd0);
            @(negedge clk);
        end
        chk("R8 done due", {63'd0, done_o}, 64'd1);
        chk(req, {hi_o, lo_o}, exp);
        @(negedge clk);
        chk("R8 done single", {63'd0, done_o}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] vals [8];
        logic [63:0] pre [3];
        logic [63:0] exp;
        string req;
        vals[0] = 32'h00000000; vals[1] = 32'h00000001; vals[2] = 32'hFFFFFFFF;
        vals[3] = 32'h7FFFFFFF; vals[4] = 32'h80000000; vals[5] = 32'h12348000;
        vals[6] = 32'hABCD7FFF; vals[7] = 32'h00030002;
        pre[0] = 64'h0; pre[1] = 64'hFFFFFFFF_80000000; pre[2] = 64'h00000000_7FFFFFFE;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset value", {hi_o, lo_o}, 64'd0);
        chk("R10 reset done", {63'd0, done_o}, 64'd0);

        // R1..R7, R12 encodings: sweep of operands, preloads, ops and modes
        for (int pi = 0; pi < 3; pi++)
            for (int ai = 0; ai < 8; ai++)
                for (int bi = 0; bi < 8; bi++)
                    for (int m = 0; m < 4; m++) begin
                        load_acc(pre[pi]);
                        exp = model(m[0], m[1], vals[ai], vals[bi], pre[pi], req);
                        run_op(m[0], m[1], vals[ai], vals[bi], exp, req);
                    end

        // R9: start held through the busy window is ignored
        load_acc(64'd0);
        op_i = 1'b0; sat_i = 1'b0; a_i = 32'd2; b_i = 32'd3; start_i = 1'b1;
        @(negedge clk);
        a_i = 32'd100; b_i = 32'd100;
        for (int i = 0; i < LAT; i++) @(negedge clk);
        start_i = 1'b0;
        chk("R9 done", {63'd0, done_o}, 64'd1);
        chk("R9 result", {hi_o, lo_o}, 64'd6);
        for (int i = 0; i < LAT + 3; i++) begin
            @(negedge clk);
            chk("R9 no extra done", {63'd0, done_o}, 64'd0);
        end
        chk("R9 result kept", {hi_o, lo_o}, 64'd6);

        // R10: clear beats loads
        load_acc(64'h11112222_33334444);
        clr_i = 1'b1; ld_hi_i = 1'b1; ld_lo_i = 1'b1; ld_data_i = 32'd5;
        @(negedge clk);
        clr_i = 1'b0; ld_hi_i = 1'b0; ld_lo_i = 1'b0;
        chk("R10 clear over load", {hi_o, lo_o}, 64'd0);

        // R10: clear beats a write-back on the same edge
        load_acc(64'h00000005_00000005);
        op_i = 1'b0; sat_i = 1'b0; a_i = 32'd2; b_i = 32'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < LAT - 1; i++) @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        chk("R10 clear over writeback", {hi_o, lo_o}, 64'd0);

        // R11: load of one word overrides write-back of that word only
        load_acc(64'd0);
        op_i = 1'b0; sat_i = 1'b0; a_i = 32'd2; b_i = 32'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < LAT - 1; i++) @(negedge clk);
        ld_hi_i = 1'b1; ld_data_i = 32'hDEADBEEF;
        @(negedge clk);
        ld_hi_i = 1'b0;
        chk("R11 load over writeback", {hi_o, lo_o}, 64'hDEADBEEF_00000006);

        // R12: saturation mode is sampled at start
        load_acc(64'h12345678_00000000);
        op_i = 1'b0; sat_i = 1'b1; a_i = 32'd1; b_i = 32'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; sat_i = 1'b0; op_i = 1'b1;
        for (int i = 0; i < LAT; i++) @(negedge clk);
        chk("R12 mode sampled", {hi_o, lo_o}, 64'h00005678_00000001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule